// File: doc/BRIEF.md
# Root-of-Trust Partition Access Controller

This block decides, for every instruction fetch and every data or debug access, whether the request may touch the flash regions that belong to the boot-time trusted firmware. It keeps a one-way execution phase: the device comes out of reset running trusted code. That phase closes for good once the trusted code has armed its exit flag and a later fetch lands in user flash outside every trusted region. After that, the regions are locked against ordinary software. Authorised debug can still reach them, and regions marked immutable never accept a write.

A small control register lets the trusted code arm the exit, authorise debug and choose whether external access is opened. The register accepts writes only while trusted execution is active, so ordinary software cannot change it later. Grant and error answers are combinational on the request in the same cycle. Phase changes and register writes take effect on the next clock edge. The region table (base, limit and write-enable per region) comes from the surrounding protection logic.

Top module: `rot_partition_ctrl`

## Requirements
- R1: While reset is asserted, the control bits EAA (bit 0), DBG (bit 1) and DONE (bit 2) of `ctl_rdata` read 0, `ext_access_o` is 0 and `trusted_o` is 0.
- R2: The partition is enabled when `cfg_part_bit` is 0. The erased value 1 disables it, and then every access and fetch is granted, the lock bit reads 0 and trusted execution never starts.
- R3: If the partition is enabled and `mission_mode` is 1 in the first clock cycle after reset is released, `trusted_o` is 1 from the following cycle. If `mission_mode` is 0 in that cycle, `trusted_o` stays 0.
- R4: While trusted, a valid fetch taken with DONE already 1, at an address in [UF_BASE, UF_LIMIT) and outside every region, clears `trusted_o` on the next cycle, even when `fetch_err` is 1.
- R5: Trusted execution continues after a fetch made while DONE is 0, a fetch that hits a region, or a fetch outside user flash.
- R6: Once trusted execution has ended, it does not return before the next reset. Control register writes are then ignored, so DONE, DBG and EAA keep their values.
- R7: Bit 4 of `ctl_rdata` (lock) reads 1 exactly when the partition is enabled and trusted execution is not active.
- R8: While locked, an access that hits a region gets `acc_err` and no `acc_grant`, unless `acc_debug` is 1 and DBG is 1. A fetch that hits a region gets `fetch_deny` and no `fetch_grant`.
- R9: With the partition enabled, a write that hits a region whose `reg_wen` bit is 0 is denied in every phase, including trusted execution and authorised debug.
- R10: A region covers the addresses from its base (inclusive) up to its limit (exclusive). A region whose base equals its limit matches nothing.
- R11: While trusted, a `ctl_we` write loads EAA from `ctl_wdata[0]` and DBG from `ctl_wdata[1]`, and sets DONE when `ctl_wdata[2]` is 1. DONE is never cleared before reset. `ext_access_o` follows EAA.
- R12: A valid access gets exactly one of `acc_grant` and `acc_err`, in the same cycle, and an idle cycle gets neither. A fetch with `fetch_err` 1 is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_part_bit | input | 1 | Sampled configuration bit, 0 enables the partition |
| mission_mode | input | 1 | Device is leaving reset into mission mode |
| reg_base | input | NUM_REG*ADDR_W | Packed region base addresses |
| reg_limit | input | NUM_REG*ADDR_W | Packed region limit addresses (exclusive) |
| reg_wen | input | NUM_REG | Per-region write permission |
| fetch_valid | input | 1 | Instruction fetch request |
| fetch_addr | input | ADDR_W | Fetch address |
| fetch_err | input | 1 | Fetch carries an error (privilege or uncorrectable) |
| acc_valid | input | 1 | Data or debug access request |
| acc_addr | input | ADDR_W | Access address |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_debug | input | 1 | Access originates from debug |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Control write data {DONE, DBG, EAA} |
| ctl_rdata | output | 5 | {lock, 0, DONE, DBG, EAA} |
| acc_grant | output | 1 | Access allowed |
| acc_err | output | 1 | Access denied, error returned |
| fetch_grant | output | 1 | Fetch allowed |
| fetch_deny | output | 1 | Fetch blocked by the lock |
| trusted_o | output | 1 | Trusted execution active |
| ext_access_o | output | 1 | External access allowed (EAA) |

## Verification
The grant, error and deny outputs depend combinationally on the request, so the bench drives each request on a falling edge and samples one time unit later, before the next rising edge. The phase flag, the control bits and the lock bit each pass through one register. The bench therefore applies the causing fetch or write, lets exactly one rising edge pass, and samples at the following falling edge. Trusted execution is due one edge after reset release, so the first check of `trusted_o` comes at the falling edge after that release edge.

// File: rtl/rot_pkg.sv
package rot_pkg;

    localparam int CTL_WR_W = 3;
    localparam int CTL_RD_W = 5;

    localparam int BIT_EAA  = 0;
    localparam int BIT_DBG  = 1;
    localparam int BIT_DONE = 2;
    localparam int BIT_LOCK = 4;

    typedef struct packed {
        logic started;  // first post-reset cycle has passed
        logic trusted;  // trusted execution active
        logic eaa;      // external access allowed
        logic dbg;      // debug authorised
        logic done;     // exit armed, sticky
    } rot_state_t;

endpackage

// File: rtl/rot_region_match.sv
module rot_region_match #(
    parameter int ADDR_W  = 16,
    parameter int NUM_REG = 4
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [NUM_REG*ADDR_W-1:0] base_flat,
    input  logic [NUM_REG*ADDR_W-1:0] limit_flat,
    output logic [NUM_REG-1:0]        hit
);

    for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
        assign lo     = base_flat[g*ADDR_W +: ADDR_W];
        assign hi     = limit_flat[g*ADDR_W +: ADDR_W];
        // inclusive base, exclusive limit; empty when lo == hi
        assign hit[g] = (addr >= lo) && (addr < hi);
    end

endmodule

// File: rtl/rot_phase_state.sv
module rot_phase_state
    import rot_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                part_en,
    input  logic                mission_mode,
    input  logic                fetch_exit,
    input  logic                ctl_we,
    input  logic [CTL_WR_W-1:0] ctl_wdata,
    output logic                trusted,
    output logic                eaa,
    output logic                dbg,
    output logic                done
);

    rot_state_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.started = 1'b1;
        if (!s_q.started) begin
            s_d.trusted = part_en & mission_mode;
        end else if (s_q.trusted && s_q.done && fetch_exit) begin
            s_d.trusted = 1'b0;
        end
        if (ctl_we && s_q.trusted) begin
            s_d.eaa  = ctl_wdata[BIT_EAA];
            s_d.dbg  = ctl_wdata[BIT_DBG];
            s_d.done = s_q.done | ctl_wdata[BIT_DONE];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign trusted = s_q.trusted;
    assign eaa     = s_q.eaa;
    assign dbg     = s_q.dbg;
    assign done    = s_q.done;

endmodule

// File: rtl/rot_partition_ctrl.sv
module rot_partition_ctrl
    import rot_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                NUM_REG  = 4,
    parameter logic [ADDR_W-1:0] UF_BASE  = 'h1000,
    parameter logic [ADDR_W-1:0] UF_LIMIT = 'h9000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_part_bit,
    input  logic                      mission_mode,
    input  logic [NUM_REG*ADDR_W-1:0] reg_base,
    input  logic [NUM_REG*ADDR_W-1:0] reg_limit,
    input  logic [NUM_REG-1:0]        reg_wen,
    input  logic                      fetch_valid,
    input  logic [ADDR_W-1:0]         fetch_addr,
    input  logic                      fetch_err,
    input  logic                      acc_valid,
    input  logic [ADDR_W-1:0]         acc_addr,
    input  logic                      acc_write,
    input  logic                      acc_debug,
    input  logic                      ctl_we,
    input  logic [CTL_WR_W-1:0]       ctl_wdata,
    output logic [CTL_RD_W-1:0]       ctl_rdata,
    output logic                      acc_grant,
    output logic                      acc_err,
    output logic                      fetch_grant,
    output logic                      fetch_deny,
    output logic                      trusted_o,
    output logic                      ext_access_o
);

    logic [NUM_REG-1:0] f_hit, a_hit;
    logic part_en, locked, in_user, fetch_exit;
    logic trusted, eaa, dbg, done;
    logic a_any, a_ro, a_block, f_block;

    rot_region_match #(.ADDR_W(ADDR_W), .NUM_REG(NUM_REG)) u_fetch_match (
        .addr       (fetch_addr),
        .base_flat  (reg_base),
        .limit_flat (reg_limit),
        .hit        (f_hit)
    );

    rot_region_match #(.ADDR_W(ADDR_W), .NUM_REG(NUM_REG)) u_acc_match (
        .addr       (acc_addr),
        .base_flat  (reg_base),
        .limit_flat (reg_limit),
        .hit        (a_hit)
    );

    assign part_en    = ~cfg_part_bit;
    assign in_user    = (fetch_addr >= UF_BASE) && (fetch_addr < UF_LIMIT);
    // faulting fetches count as well: fetch_err is deliberately not used here
    assign fetch_exit = fetch_valid & in_user & ~(|f_hit);

    rot_phase_state u_state (
        .clk          (clk),
        .rst_n        (rst_n),
        .part_en      (part_en),
        .mission_mode (mission_mode),
        .fetch_exit   (fetch_exit),
        .ctl_we       (ctl_we),
        .ctl_wdata    (ctl_wdata),
        .trusted      (trusted),
        .eaa          (eaa),
        .dbg          (dbg),
        .done         (done)
    );

    assign locked = part_en & ~trusted;

    always_comb begin
        a_any   = |a_hit;
        a_ro    = |(a_hit & ~reg_wen);
        a_block = part_en & a_any &
                  ((locked & ~(acc_debug & dbg)) | (acc_write & a_ro));
        f_block = part_en & (|f_hit) & locked;
    end

    assign acc_grant   = acc_valid & ~a_block;
    assign acc_err     = acc_valid &  a_block;
    assign fetch_grant = fetch_valid & ~fetch_err & ~f_block;
    assign fetch_deny  = fetch_valid & f_block;

    always_comb begin
        ctl_rdata           = '0;
        ctl_rdata[BIT_EAA]  = eaa;
        ctl_rdata[BIT_DBG]  = dbg;
        ctl_rdata[BIT_DONE] = done;
        ctl_rdata[BIT_LOCK] = locked;
    end

    assign trusted_o    = trusted;
    assign ext_access_o = eaa;

endmodule

// File: rtl/rot_partition_chk.sv
module rot_partition_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_part_bit,
    input logic       acc_valid,
    input logic       acc_grant,
    input logic       acc_err,
    input logic       trusted_o,
    input logic [4:0] ctl_rdata
);

    logic [1:0] cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= 2'd0;
        end else if (cyc_q != 2'd2) begin
            cyc_q <= cyc_q + 2'd1;
        end
    end

    p_grant_xor_r12: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> (acc_grant ^ acc_err));

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (!acc_grant && !acc_err));

    p_disabled_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_part_bit && acc_valid) |-> acc_grant);

    p_lock_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[4] == (!cfg_part_bit && !trusted_o));

    p_no_reentry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 2'd2 && !trusted_o) |=> !trusted_o);

    p_frozen_ctl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 2'd2 && !trusted_o) |=> $stable(ctl_rdata[2:0]));

    p_done_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[2] |=> ctl_rdata[2]);

endmodule

bind rot_partition_ctrl rot_partition_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_part_bit (cfg_part_bit),
    .acc_valid    (acc_valid),
    .acc_grant    (acc_grant),
    .acc_err      (acc_err),
    .trusted_o    (trusted_o),
    .ctl_rdata    (ctl_rdata)
);

// File: tb/rot_partition_ctrl_test.sv
module rot_partition_ctrl_test;

    localparam int CLK_P   = 10;
    localparam int ADDR_W  = 16;
    localparam int NUM_REG = 4;

    typedef struct packed {
        logic [15:0] addr;
        logic        wr;
        logic        dbg;
        logic        exp;
    } vec_t;

    // Walked while locked with DBG = 1. Regions:
    // 0:[1000,1400) read-only, 1:[1400,1800) rw, 2:[1800,1900) rw, 3:[2000,2000) empty
    localparam vec_t VEC [12] = '{
        '{16'h1000, 1'b0, 1'b0, 1'b0},  // R8 R10 base inclusive, locked
        '{16'h13FF, 1'b0, 1'b1, 1'b1},  // R8 debug read allowed
        '{16'h13FF, 1'b1, 1'b1, 1'b0},  // R9 immutable write, even debug
        '{16'h1400, 1'b1, 1'b1, 1'b1},  // R8 debug write to rw region
        '{16'h1400, 1'b1, 1'b0, 1'b0},  // R8 locked non-debug write
        '{16'h18FF, 1'b0, 1'b0, 1'b0},  // R10 last address inside
        '{16'h1900, 1'b0, 1'b0, 1'b1},  // R10 limit exclusive
        '{16'h2000, 1'b0, 1'b0, 1'b1},  // R10 empty region
        '{16'h0FFF, 1'b1, 1'b0, 1'b1},  // R10 below first base
        '{16'h5000, 1'b1, 1'b0, 1'b1},  // R8 outside all regions
        '{16'h17FF, 1'b0, 1'b1, 1'b1},  // R8 debug read rw region
        '{16'h1900, 1'b1, 1'b1, 1'b1}   // R10 limit exclusive, write
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_part_bit = 1'b0;
    logic mission_mode = 1'b1;
    logic [NUM_REG*ADDR_W-1:0] reg_base, reg_limit;
    logic [NUM_REG-1:0] reg_wen;
    logic fetch_valid = 1'b0;
    logic [ADDR_W-1:0] fetch_addr = '0;
    logic fetch_err = 1'b0;
    logic acc_valid = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic acc_write = 1'b0;
    logic acc_debug = 1'b0;
    logic ctl_we = 1'b0;
    logic [2:0] ctl_wdata = '0;
    logic [4:0] ctl_rdata;
    logic acc_grant, acc_err, fetch_grant, fetch_deny, trusted_o, ext_access_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    assign reg_base  = {16'h2000, 16'h1800, 16'h1400, 16'h1000};
    assign reg_limit = {16'h2000, 16'h1900, 16'h1800, 16'h1400};
    assign reg_wen   = 4'b1110;

    always #(CLK_P/2) clk = ~clk;

    rot_partition_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_part_bit(cfg_part_bit),
        .mission_mode(mission_mode), .reg_base(reg_base), .reg_limit(reg_limit),
        .reg_wen(reg_wen), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .fetch_err(fetch_err), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_write(acc_write), .acc_debug(acc_debug), .ctl_we(ctl_we),
        .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .acc_grant(acc_grant),
        .acc_err(acc_err), .fetch_grant(fetch_grant), .fetch_deny(fetch_deny),
        .trusted_o(trusted_o), .ext_access_o(ext_access_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        fetch_valid = 1'b0; fetch_err = 1'b0; acc_valid = 1'b0;
        acc_write = 1'b0; acc_debug = 1'b0; ctl_we = 1'b0;
    endtask

    task automatic boot(input logic cfg, input logic mm);
        @(negedge clk);
        rst_n = 1'b0; cfg_part_bit = cfg; mission_mode = mm; idle();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        step();
    endtask

    task automatic fetch(input logic [15:0] a, input logic err);
        fetch_valid = 1'b1; fetch_addr = a; fetch_err = err;
        step();
        idle();
    endtask

    task automatic ctl_write(input logic [2:0] d);
        ctl_we = 1'b1; ctl_wdata = d;
        step();
        idle();
    endtask

    task automatic access(input logic [15:0] a, input logic wr, input logic dbg);
        acc_valid = 1'b1; acc_addr = a; acc_write = wr; acc_debug = dbg;
        #1;
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: state held in reset
        @(negedge clk);
        #1;
        chk("R1 ctl bits in reset", {29'd0, ctl_rdata[2:0]}, 32'd0);
        chk("R1 ext access in reset", {31'd0, ext_access_o}, 32'd0);
        chk("R1 trusted in reset", {31'd0, trusted_o}, 32'd0);

        boot(1'b0, 1'b1);
        chk("R3 trusted after boot", {31'd0, trusted_o}, 32'd1);
        chk("R7 unlocked while trusted", {31'd0, ctl_rdata[4]}, 32'd0);

        access(16'h1000, 1'b0, 1'b0);
        chk("R8 trusted read of region", {31'd0, acc_grant}, 32'd1);
        idle(); access(16'h1000, 1'b1, 1'b0);
        chk("R9 immutable write while trusted", {30'd0, acc_grant, acc_err}, 32'd1);
        idle(); #1;
        chk("R12 idle no answer", {30'd0, acc_grant, acc_err}, 32'd0);

        ctl_write(3'b011);
        chk("R11 EAA DBG load", {29'd0, ctl_rdata[2:0]}, 32'd3);
        chk("R11 ext access follows EAA", {31'd0, ext_access_o}, 32'd1);
        ctl_write(3'b010);
        chk("R11 EAA cleared", {31'd0, ext_access_o}, 32'd0);

        fetch(16'h5000, 1'b0);
        chk("R5 exit fetch without DONE", {31'd0, trusted_o}, 32'd1);
        ctl_write(3'b110);
        chk("R11 DONE set", {29'd0, ctl_rdata[2:0]}, 32'd6);
        ctl_write(3'b010);
        chk("R11 DONE not cleared", {31'd0, ctl_rdata[2]}, 32'd1);
        fetch(16'h1200, 1'b0);
        chk("R5 region fetch keeps trusted", {31'd0, trusted_o}, 32'd1);
        fetch(16'h9000, 1'b0);
        chk("R5 fetch outside user flash", {31'd0, trusted_o}, 32'd1);

        fetch_valid = 1'b1; fetch_addr = 16'h5000; fetch_err = 1'b1;
        #1;
        chk("R12 faulting fetch not granted", {31'd0, fetch_grant}, 32'd0);
        step(); idle();
        chk("R4 faulting fetch ends trusted", {31'd0, trusted_o}, 32'd0);
        chk("R7 locked after exit", {31'd0, ctl_rdata[4]}, 32'd1);

        ctl_write(3'b001);
        chk("R6 ctl write ignored", {29'd0, ctl_rdata[2:0]}, 32'd6);
        fetch_valid = 1'b1; fetch_addr = 16'h1000;
        #1;
        chk("R8 locked fetch denied", {30'd0, fetch_grant, fetch_deny}, 32'd1);
        step(); idle();
        chk("R6 no re-entry", {31'd0, trusted_o}, 32'd0);

        foreach (VEC[i]) begin
            access(VEC[i].addr, VEC[i].wr, VEC[i].dbg);
            chk($sformatf("R8 R9 R10 vector %0d grant", i), {31'd0, acc_grant}, {31'd0, VEC[i].exp});
            chk($sformatf("R12 vector %0d err", i), {31'd0, acc_err}, {31'd0, ~VEC[i].exp});
            idle();
            @(negedge clk);
        end

        boot(1'b0, 1'b0);
        chk("R3 no mission mode no trust", {31'd0, trusted_o}, 32'd0);
        access(16'h1400, 1'b0, 1'b0);
        chk("R8 locked without mission", {31'd0, acc_err}, 32'd1);
        idle();

        boot(1'b1, 1'b1);
        chk("R2 disabled no trust", {31'd0, trusted_o}, 32'd0);
        chk("R2 disabled lock clear", {31'd0, ctl_rdata[4]}, 32'd0);
        access(16'h1000, 1'b1, 1'b0);
        chk("R2 disabled write granted", {31'd0, acc_grant}, 32'd1);
        idle();
        fetch_valid = 1'b1; fetch_addr = 16'h1000;
        #1;
        chk("R2 disabled fetch granted", {31'd0, fetch_grant}, 32'd1);
        idle();

        boot(1'b0, 1'b1);
        ctl_write(3'b100);
        fetch(16'h1900, 1'b0);
        chk("R4 clean exit fetch", {31'd0, trusted_o}, 32'd0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule